// File: doc/BRIEF.md
# Eight-Channel Prescaled Compare Timer Bank

The block holds eight identical 16-bit timer channels that run from one slow reference clock. Each channel divides the reference by a power of two, counts upward, and compares its count against two compare registers. A match can set a sticky status flag, and a match on the second compare also wraps the counter back to zero. This gives a periodic tick, or a one-shot event if software stops the channel after the first match.

Three shared registers turn the status flags into outputs. The first is an interrupt enable mask. The second combines a non-maskable-event mask with reset-request enables. The third is a routing word that gives every channel a 4-bit interrupt line number. Software uses the setup register's "configured" flag to tell whether a channel has already been claimed. All state is reached through one register port, selected by a channel index and a register offset. Reads are combinational.

Top module: `tmr_bank`

## Requirements
- R1: The counter advances once every 2^scale reference cycles while enabled. Scale is setup bits [3:0], valid 0 to 8.
- R2: The setup register has this layout: bit 15 enable, bit 12 configured (read-only), bits 9:8 compare-2 mode, bits 7:6 compare-1 mode, bits 3:0 scale. While enable is 0 the counter holds its value.
- R3: The first setup write sets the configured bit. Later setup writes change only the enable bit. Scale and both modes stay locked until reset.
- R4: The register offsets are 0 setup, 1 counter, 2 compare-1, 3 compare-2, 4 status, 5 interrupt enables, 6 NMI/reset enables, 7 routing. The counter and both compare registers are 16 bits, and each reads back the value last written.
- R5: A prescaled tick taken while the counter equals compare-2 loads the counter with 0. If compare-2 mode is 3, it also sets status bit 1.
- R6: A prescaled tick taken while the counter equals compare-1, with compare-1 mode 3, sets status bit 0. The counter keeps counting. Status bits are sticky and are cleared by writing 1 to them at offset 4. A set in the same cycle wins over a clear.
- R7: In the interrupt enable register, bit n gates channel n's status bit 0 and bit n+8 gates its status bit 1. `irq_out[n]` is high while any gated pair is set.
- R8: The NMI/reset register uses the same bit positions n and n+8 to drive `nmi_out[n]`.
- R9: Bit n+24 of the NMI/reset register drives `rst_out[n]` from any set status bit, only for channels 0 to 5. For channels 6 and 7 the bit has no effect.
- R10: A routing write with channel n writes wdata[3:0] into both 4-bit fields at offsets (n mod 4)*4 and (n mod 4)*4+16. `irq_line[4n+3:4n]` shows channel n's routed number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | 3 | Channel index |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register |
| irq_out | output | 8 | Per-channel interrupt level |
| nmi_out | output | 8 | Per-channel non-maskable event level |
| rst_out | output | 8 | Per-channel reset request level |
| irq_line | output | 32 | Routed 4-bit line number per channel |

## Verification
A wrong prescaler phase or wrap decision shows up as a counter value that is off by one, and it shows within a single prescaled period. The bench stops each channel on a known edge and reads the counter back, so such an error is visible right away. A status flag that is lost or set falsely changes `irq_out`, `nmi_out` or `rst_out` in the same cycle, because these outputs are pure gating of registered state. A routing or lock fault shows on the next read of the affected register.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH       = 8;
    localparam int CNT_W     = 16;
    localparam int PRE_W     = 8;
    localparam int SCALE_MAX = 8;
    localparam int RST_CH    = 6;
    localparam int LINE_W    = 4;

    typedef enum logic [2:0] {
        OFF_SETUP = 3'd0,
        OFF_CNT   = 3'd1,
        OFF_CMP1  = 3'd2,
        OFF_CMP2  = 3'd3,
        OFF_STAT  = 3'd4,
        OFF_IEN   = 3'd5,
        OFF_NEN   = 3'd6,
        OFF_ROUTE = 3'd7
    } reg_off_e;

    typedef struct packed {
        logic       en;
        logic       done;
        logic [1:0] m2;
        logic [1:0] m1;
        logic [3:0] scale;
    } setup_t;

    function automatic logic [PRE_W-1:0] pre_limit(input logic [3:0] scale);
        logic [3:0] s;
        logic [PRE_W:0] p;
        s = (scale > 4'(SCALE_MAX)) ? 4'(SCALE_MAX) : scale;
        p = (PRE_W+1)'(1) << s;
        return PRE_W'(p - (PRE_W+1)'(1));
    endfunction

    function automatic logic [CNT_W-1:0] pack_setup(input setup_t c);
        return {c.en, 2'b00, c.done, 2'b00, c.m2, c.m1, 2'b00, c.scale};
    endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       clr,
    input  logic [3:0] scale,
    output logic       tick
);
    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] limit;

    assign limit = pre_limit(scale);
    assign tick  = en && (pre == limit);

    always_ff @(posedge clk) begin
        if (rst || clr || !en) pre <= '0;
        else if (tick)         pre <= '0;
        else                   pre <= pre + 1'b1;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && limit != '0) |=> !tick); // R1
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       off,
    input  logic [CNT_W-1:0] wdata,
    output setup_t           cfg,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp1,
    output logic [CNT_W-1:0] cmp2,
    output logic [1:0]       st
);
    logic tick;
    logic cnt_we, clr_we;
    logic hit1, hit2;

    assign cnt_we = wr_en && (off == OFF_CNT);
    assign clr_we = wr_en && (off == OFF_STAT);
    assign hit1   = tick && (cnt == cmp1);
    assign hit2   = tick && (cnt == cmp2);

    tmr_prescale u_pre (
        .clk   (clk),
        .rst   (rst),
        .en    (cfg.en),
        .clr   (cnt_we),
        .scale (cfg.scale),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en && off == OFF_SETUP) begin
            cfg.en <= wdata[15];
            if (!cfg.done) begin
                cfg.done  <= 1'b1;
                cfg.m2    <= wdata[9:8];
                cfg.m1    <= wdata[7:6];
                cfg.scale <= wdata[3:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp1 <= '0;
            cmp2 <= '0;
        end else begin
            if (wr_en && off == OFF_CMP1) cmp1 <= wdata;
            if (wr_en && off == OFF_CMP2) cmp2 <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt <= '0;
        else if (cnt_we) cnt <= wdata;
        else if (hit2)   cnt <= '0;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st[0] <= (hit1 && cfg.m1 == 2'b11) || (st[0] && !(clr_we && wdata[0]));
            st[1] <= (hit2 && cfg.m2 == 2'b11) || (st[1] && !(clr_we && wdata[1]));
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!cfg.en && !cnt_we) |=> $stable(cnt)); // R2
    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (rst)
        cfg.done |=> cfg.done); // R3
    AST_CFG_LOCK: assert property (@(posedge clk) disable iff (rst)
        cfg.done |=> ($stable(cfg.scale) && $stable(cfg.m1) && $stable(cfg.m2))); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (hit2 && !cnt_we) |=> (cnt == '0)); // R5
    AST_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st[1] && !(clr_we && wdata[1])) |=> st[1]); // R6
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N    = NCH,
    localparam int CH_W = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [CH_W-1:0]   reg_ch,
    input  logic [2:0]        reg_off,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [N-1:0]      irq_out,
    output logic [N-1:0]      nmi_out,
    output logic [N-1:0]      rst_out,
    output logic [N*LINE_W-1:0] irq_line
);
    setup_t           cfg  [N];
    logic [CNT_W-1:0] cnt  [N];
    logic [CNT_W-1:0] cmp1 [N];
    logic [CNT_W-1:0] cmp2 [N];
    logic [1:0]       st   [N];
    logic [31:0]      ien, nen, route;
    logic [4:0]       slot_lo;

    assign slot_lo = {1'b0, reg_ch[1:0], 2'b00};

    for (genvar n = 0; n < N; n++) begin : g_ch
        tmr_channel u_ch (
            .clk   (clk),
            .rst   (rst),
            .wr_en (reg_we && reg_ch == CH_W'(n)),
            .off   (reg_off),
            .wdata (reg_wdata[CNT_W-1:0]),
            .cfg   (cfg[n]),
            .cnt   (cnt[n]),
            .cmp1  (cmp1[n]),
            .cmp2  (cmp2[n]),
            .st    (st[n])
        );

        assign irq_out[n] = (st[n][0] && ien[n]) || (st[n][1] && ien[n+8]);
        assign nmi_out[n] = (st[n][0] && nen[n]) || (st[n][1] && nen[n+8]);
        assign irq_line[n*LINE_W +: LINE_W] = route[(n%4)*LINE_W +: LINE_W];

        if (n < RST_CH) begin : g_rst
            assign rst_out[n] = (st[n] != 2'b00) && nen[n+24];
        end else begin : g_norst
            assign rst_out[n] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            nen   <= '0;
            route <= '0;
        end else if (reg_we) begin
            case (reg_off)
                OFF_IEN: ien <= reg_wdata;
                OFF_NEN: nen <= reg_wdata;
                OFF_ROUTE: begin
                    route[slot_lo +: LINE_W]         <= reg_wdata[LINE_W-1:0];
                    route[slot_lo + 5'd16 +: LINE_W] <= reg_wdata[LINE_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_off)
            OFF_SETUP: reg_rdata = {16'h0, pack_setup(cfg[reg_ch])};
            OFF_CNT:   reg_rdata = {16'h0, cnt[reg_ch]};
            OFF_CMP1:  reg_rdata = {16'h0, cmp1[reg_ch]};
            OFF_CMP2:  reg_rdata = {16'h0, cmp2[reg_ch]};
            OFF_STAT:  reg_rdata = {30'h0, st[reg_ch]};
            OFF_IEN:   reg_rdata = ien;
            OFF_NEN:   reg_rdata = nen;
            default:   reg_rdata = route;
        endcase
    end

    AST_ROUTE_PAIR: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_off == OFF_ROUTE) |=> (route[15:0] == route[31:16])); // R10
endmodule

// File: tb/sim_tmr_bank.sv
module sim_tmr_bank;
    localparam time HALF = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic [2:0]  reg_ch;
    logic [2:0]  reg_off;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [7:0]  irq_out, nmi_out, rst_out;
    logic [31:0] irq_line;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #HALF clk = ~clk;

    tmr_bank u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch),
        .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .nmi_out(nmi_out), .rst_out(rst_out),
        .irq_line(irq_line)
    );

    // monitor: pops expected items and compares against the ports
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            case (it.kind)
                0: act = reg_rdata;
                1: act = {24'h0, irq_out};
                2: act = {24'h0, nmi_out};
                3: act = {24'h0, rst_out};
                default: act = irq_line;
            endcase
            total++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [2:0] ch, input logic [2:0] off, input logic [31:0] d);
        reg_we = 1'b1; reg_ch = ch; reg_off = off; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic chk(input int kind, input logic [2:0] ch, input logic [2:0] off,
                       input logic [31:0] exp, input string tag);
        item_t it;
        reg_ch = ch; reg_off = off;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        @(posedge clk); #1;
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_ch = '0; reg_off = '0; reg_wdata = '0;
        step(3);
        rst = 1'b0;
        step(1);

        chk(0, 0, 0, 32'h0, "R2 reset setup");
        chk(1, 0, 0, 32'h0, "R7 reset irq");
        chk(0, 0, 7, 32'h0, "R10 reset route");

        // first setup write: modes 3/3, scale 0, disabled
        wr(0, 0, 32'h03C0);
        chk(0, 0, 0, 32'h13C0, "R3 configured set");
        wr(0, 0, 32'h0005);
        chk(0, 0, 0, 32'h13C0, "R3 fields locked");

        wr(0, 1, 32'h0005);
        step(3);
        chk(0, 0, 1, 32'h5, "R2 hold while disabled");

        wr(0, 2, 32'h0003);
        wr(0, 3, 32'h000A);
        chk(0, 0, 3, 32'hA, "R4 compare-2 readback");
        wr(0, 1, 32'h0000);

        wr(0, 0, 32'h8000);   // enable, edge E0
        step(2);              // E1, E2
        wr(0, 0, 32'h0000);   // stop at E3
        chk(0, 0, 1, 32'h3, "R1 scale0 count");
        chk(0, 0, 4, 32'h0, "R6 no status yet");

        wr(0, 0, 32'h8000);   // F0
        step(8);              // F1..F8
        wr(0, 0, 32'h0000);   // F9
        chk(0, 0, 1, 32'h1, "R5 wrap after compare-2");
        chk(0, 0, 4, 32'h3, "R6 both status bits");

        wr(0, 4, 32'h1);
        chk(0, 0, 4, 32'h2, "R6 write-1 clear");

        wr(0, 5, 32'h0000_0100);
        chk(1, 0, 0, 32'h01, "R7 irq from compare-2");

        wr(0, 7, 32'h7);
        chk(0, 0, 7, 32'h0007_0007, "R10 route both fields");
        wr(5, 7, 32'hA);
        chk(0, 0, 7, 32'h00A7_00A7, "R10 route slot 1");
        chk(4, 0, 0, 32'h00A7_00A7, "R10 line per channel");

        // channel 1: scale 2
        wr(1, 3, 32'hFFFE);
        wr(1, 0, 32'h8302);   // E0
        step(7);              // E1..E7
        wr(1, 0, 32'h0000);   // E8
        chk(0, 1, 1, 32'h2, "R1 scale2 count");
        chk(0, 1, 0, 32'h1302, "R3 enable still writable");

        // channel 6: compare values zero, one tick
        wr(6, 0, 32'h83C0);
        wr(6, 0, 32'h0000);
        chk(0, 6, 4, 32'h3, "R6 channel6 status");

        wr(0, 6, 32'h4100_4100);
        chk(2, 0, 0, 32'h41, "R8 nmi gating");
        chk(3, 0, 0, 32'h01, "R9 reset only low channels");
        chk(1, 0, 0, 32'h01, "R7 unaffected by nmi mask");

        step(2);
        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule